// File: doc/BRIEF.md
# Serial Flash Write and Erase Sequencer

This block sits on the host side of a single-lane SPI NOR flash and runs the multi-transaction operations that change the flash contents. There are three: a write of the non-volatile configuration register, a sector erase, and a page program. A single start pulse with an operation code, a 24-bit address and a byte count expands into a chain of separate chip-select frames. The chain is a write-enable frame, an optional status read that confirms the write-enable latch, the command frame itself, and then status-read frames repeated until the device reports that it is no longer busy.

Program data and the configuration byte come from a small byte buffer, which the host fills through a write port before it issues start. The block reports completion with a one-cycle `done` pulse. `error` is raised in the same cycle when the request is malformed, when the latch was not set, or when the busy bit did not clear within the poll budget. The SCK divider, buffer depth, minimum chip-select high time, poll budget and latch check are all parameters.

Top module: `flash_wr_seq`

## Requirements
- R1: Every accepted operation starts with a frame that holds only the single byte 0x06.
- R2: With the latch check enabled, the next frame is two bytes long and begins with 0x05. If bit 1 of the status byte read in it is 0, no command frame follows and the operation ends with `done` and `error` both high.
- R3: A configuration write (req_op = 0) sends the frame 0x71, 0x00, 0x00, 0x02, then buffer entry 0, whatever req_addr holds.
- R4: A sector erase (req_op = 1) sends the frame 0x20 followed by the three bytes of req_addr, most significant first.
- R5: A page program (req_op = 2) sends 0x02, the three address bytes most significant first, and then buffer entries 0 to req_len-1 in order.
- R6: After the command frame, two-byte frames beginning with 0x05 repeat until a status byte has bit 0 equal to 0. The operation then ends with `done` high and `error` low.
- R7: If POLL_MAX consecutive status frames all read bit 0 as 1, the block issues no further frames and ends with `done` and `error` both high.
- R8: Between any two frames, CS_n stays high for at least GAP_SCK*2*DIV clock cycles.
- R9: The SPI link runs in mode 0. SCK is low whenever CS_n is high. MOSI changes only while SCK is low and carries each byte MSB first. MISO is sampled on the rising SCK edge.
- R10: A request with req_op = 3, or a program with req_len of 0 or greater than DEPTH, produces `done` and `error` in the cycle after start and no frame.
- R11: Out of reset, CS_n is high, SCK is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | 0 config write, 1 sector erase, 2 page program, 3 invalid |
| req_addr | input | 24 | Flash byte address (ignored for config write) |
| req_len | input | $clog2(DEPTH+1) | Number of program bytes |
| start | input | 1 | Request pulse, accepted when idle |
| buf_we | input | 1 | Buffer write strobe |
| buf_idx | input | $clog2(DEPTH) | Buffer write index |
| buf_wdata | input | 8 | Buffer write byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A rejected request must show `done` and `error` at the very first sample after the clock edge that captured start, so the bench checks that sample exactly. An accepted operation lasts a variable number of polls. For these the bench waits for the `done` pulse under a bound, then judges the frame log that its flash model captured at each CS_n rise against the counts and bytes it computes from the request, the model's busy setting and POLL_MAX. Chip-select high time is counted in clock edges by a monitor, and MOSI and SCK are sampled on the falling clock edge, so no check depends on the ordering of events at the active edge.

// File: rtl/flash_seq_pkg.sv
// Shared types and opcodes for the flash write/erase sequencer.
// Assumes a flash with 3-byte addressing and single-lane transfers.
package flash_seq_pkg;
    typedef enum logic [1:0] {OP_CFG = 2'd0, OP_ERASE = 2'd1, OP_PROG = 2'd2, OP_BAD = 2'd3} op_e;
    typedef enum logic [1:0] {FR_WREN, FR_WELCHK, FR_CMD, FR_POLL} frame_e;
    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} state_e;

    localparam logic [7:0]  OPC_WREN  = 8'h06;
    localparam logic [7:0]  OPC_RDSR  = 8'h05;
    localparam logic [7:0]  OPC_WRCFG = 8'h71;
    localparam logic [7:0]  OPC_ERASE = 8'h20;
    localparam logic [7:0]  OPC_PROG  = 8'h02;
    localparam logic [23:0] CFG_ADDR  = 24'h000002;
endpackage

// File: rtl/flash_seq_shift.sv
// One-byte SPI mode-0 shift engine.
// What it does: shifts one byte out on MOSI, MSB first, and samples MISO on each rising SCK.
// Assumes: chip select is owned by the caller, and start is honoured only while idle.
// Only the last two received bits are kept, because the caller looks only at status bits 1 and 0.
module flash_seq_shift #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [1:0] stat,
    output logic       sck,
    output logic       mosi
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_cnt;
    logic [2:0]    bits;
    logic [7:0]    shreg;

    assign mosi = shreg[7];

    // Byte engine: SCK is divided from clk, MISO is sampled on the rise and the next bit is shifted on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            stat    <= 2'b00;
            sck     <= 1'b0;
            shreg   <= 8'h00;
            div_cnt <= '0;
            bits    <= 3'd0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    shreg   <= tx;
                    div_cnt <= '0;
                    bits    <= 3'd0;
                    sck     <= 1'b0;
                end
            end else if (div_cnt == CW'(DIV - 1)) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck  <= 1'b1;
                    stat <= {stat[0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bits == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bits  <= bits + 3'd1;
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + CW'(1);
            end
        end
    end

    // R9: MOSI holds while SCK is high.
    assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    // R9: SCK toggles only while a byte is being shifted.
    assert_sck_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy);
endmodule

// File: rtl/flash_seq_buf.sv
// Program/config byte buffer.
// What it does: the host writes bytes by index, and the sequencer reads them combinationally by index.
// Assumes: indices stay below DEPTH, which the caller guarantees.
module flash_seq_buf #(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // Storage: cleared on reset, written one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_seq_ctrl.sv
// Transaction sequencer.
// What it does: expands one request into a chain of chip-select frames
// (write-enable, optional latch check, command, status poll loop) and decides the outcome.
// Assumes: the byte engine returns status bits [1:0] of the last byte shifted.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int DIV       = 2,
    parameter int GAP_SCK   = 2,
    parameter int POLL_MAX  = 64,
    parameter bit WEL_CHECK = 1'b1,
    parameter int LW        = $clog2(DEPTH + 1),
    parameter int IW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [23:0]   addr,
    input  logic [LW-1:0] len,
    input  logic          sh_busy,
    input  logic          sh_done,
    input  logic [1:0]    sh_stat,
    input  logic [7:0]    buf_data,
    output logic [IW-1:0] buf_idx,
    output logic          sh_start,
    output logic [7:0]    sh_tx,
    output logic          cs_n,
    output logic          busy,
    output logic          done,
    output logic          error
);
    localparam int GAP_CLK = GAP_SCK * 2 * DIV;
    localparam int GW      = $clog2(GAP_CLK + 1);
    localparam int PW      = $clog2(POLL_MAX + 1);
    localparam int FW      = LW + 3;

    state_e        state;
    frame_e        kind, next_kind;
    op_e           op_q;
    logic [23:0]   addr_q, eff_addr;
    logic [LW-1:0] len_q;
    logic [FW-1:0] idx, flen;
    logic [GW-1:0] gap_cnt, hi_cnt;
    logic [PW-1:0] poll_cnt;
    logic [7:0]    opcode, tx_byte;
    logic          pend, fin, fail, req_ok;

    assign busy     = (state != ST_IDLE);
    assign eff_addr = (op_q == OP_CFG) ? CFG_ADDR : addr_q;
    assign buf_idx  = IW'(idx - FW'(4));
    assign req_ok   = (op_e'(op) != OP_BAD) &&
                      ((op_e'(op) != OP_PROG) || ((len != '0) && (len <= LW'(DEPTH))));

    // Opcode selection for the command frame.
    always_comb begin
        case (op_q)
            OP_CFG:   opcode = OPC_WRCFG;
            OP_ERASE: opcode = OPC_ERASE;
            default:  opcode = OPC_PROG;
        endcase
    end

    // Frame length in bytes for the current frame kind.
    always_comb begin
        case (kind)
            FR_WREN: flen = FW'(1);
            FR_CMD:  flen = (op_q == OP_CFG)   ? FW'(5) :
                            (op_q == OP_ERASE) ? FW'(4) : FW'(4) + FW'(len_q);
            default: flen = FW'(2);
        endcase
    end

    // Byte to send at position idx of the current frame.
    always_comb begin
        case (kind)
            FR_WREN: tx_byte = OPC_WREN;
            FR_CMD: begin
                case (idx)
                    FW'(0):  tx_byte = opcode;
                    FW'(1):  tx_byte = eff_addr[23:16];
                    FW'(2):  tx_byte = eff_addr[15:8];
                    FW'(3):  tx_byte = eff_addr[7:0];
                    default: tx_byte = buf_data;
                endcase
            end
            default: tx_byte = (idx == '0) ? OPC_RDSR : 8'h00;
        endcase
    end

    // Main sequencer: frame launch, per-byte progress, end-of-frame decision, gap timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= FR_WREN;
            next_kind <= FR_WREN;
            op_q      <= OP_CFG;
            addr_q    <= '0;
            len_q     <= '0;
            idx       <= '0;
            gap_cnt   <= '0;
            poll_cnt  <= '0;
            pend      <= 1'b0;
            fin       <= 1'b0;
            fail      <= 1'b0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            error     <= 1'b0;
            sh_start  <= 1'b0;
            sh_tx     <= 8'h00;
        end else begin
            done     <= 1'b0;
            error    <= 1'b0;
            sh_start <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!req_ok) begin
                            done  <= 1'b1;
                            error <= 1'b1;
                        end else begin
                            op_q   <= op_e'(op);
                            addr_q <= addr;
                            len_q  <= len;
                            kind   <= FR_WREN;
                            idx    <= '0;
                            pend   <= 1'b1;
                            fin    <= 1'b0;
                            fail   <= 1'b0;
                            cs_n   <= 1'b0;
                            state  <= ST_FRAME;
                        end
                    end
                end
                ST_FRAME: begin
                    if (pend && !sh_busy) begin
                        sh_start <= 1'b1;
                        sh_tx    <= tx_byte;
                        pend     <= 1'b0;
                    end else if (sh_done) begin
                        if (idx == flen - FW'(1)) begin
                            cs_n    <= 1'b1;
                            state   <= ST_GAP;
                            gap_cnt <= GW'(GAP_CLK - 1);
                            case (kind)
                                FR_WREN:   next_kind <= WEL_CHECK ? FR_WELCHK : FR_CMD;
                                FR_WELCHK: begin
                                    if (sh_stat[1]) next_kind <= FR_CMD;
                                    else begin
                                        fin  <= 1'b1;
                                        fail <= 1'b1;
                                    end
                                end
                                FR_CMD: begin
                                    next_kind <= FR_POLL;
                                    poll_cnt  <= '0;
                                end
                                default: begin
                                    if (!sh_stat[0]) fin <= 1'b1;
                                    else if (poll_cnt == PW'(POLL_MAX - 1)) begin
                                        fin  <= 1'b1;
                                        fail <= 1'b1;
                                    end else begin
                                        poll_cnt  <= poll_cnt + PW'(1);
                                        next_kind <= FR_POLL;
                                    end
                                end
                            endcase
                        end else begin
                            idx  <= idx + FW'(1);
                            pend <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == '0) begin
                        if (fin) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            error <= fail;
                        end else begin
                            kind  <= next_kind;
                            idx   <= '0;
                            pend  <= 1'b1;
                            cs_n  <= 1'b0;
                            state <= ST_FRAME;
                        end
                    end else begin
                        gap_cnt <= gap_cnt - GW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Observation counter of CS_n high cycles, saturating, for the gap property.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= GW'(GAP_CLK);
        else if (!cs_n) hi_cnt <= '0;
        else if (hi_cnt != GW'(GAP_CLK)) hi_cnt <= hi_cnt + GW'(1);
    end

    // R8: a new frame opens only after the minimum high time.
    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(GAP_CLK)));
    // R1: an accepted request always begins with the write-enable frame.
    assert_wren_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (kind == FR_WREN) && !cs_n);
    // R6: completion is reported only with chip select released.
    assert_done_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n && !busy);
    // R7: the error flag never appears without done.
    assert_error_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
    // R10: a malformed request is rejected on the next cycle.
    assert_bad_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !req_ok) |=> done && error && cs_n);
endmodule

// File: rtl/flash_wr_seq.sv
// Top of the serial flash write/erase sequencer.
// What it does: ties the request port, the byte buffer, the sequencer and the SPI byte engine together.
// Assumes: a single-lane flash in SPI mode 0 with 3-byte addressing.
module flash_wr_seq #(
    parameter int DEPTH     = 8,
    parameter int DIV       = 2,
    parameter int GAP_SCK   = 2,
    parameter int POLL_MAX  = 64,
    parameter bit WEL_CHECK = 1'b1,
    parameter int LW        = $clog2(DEPTH + 1),
    parameter int IW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req_op,
    input  logic [23:0]   req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          start,
    input  logic          buf_we,
    input  logic [IW-1:0] buf_idx,
    input  logic [7:0]    buf_wdata,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          cs_n,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    logic          sh_start, sh_busy, sh_done;
    logic [7:0]    sh_tx, rd_data;
    logic [1:0]    sh_stat;
    logic [IW-1:0] rd_idx;

    flash_seq_buf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_idx(buf_idx),
        .wr_data(buf_wdata), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    flash_seq_ctrl #(
        .DEPTH(DEPTH), .DIV(DIV), .GAP_SCK(GAP_SCK), .POLL_MAX(POLL_MAX),
        .WEL_CHECK(WEL_CHECK), .LW(LW), .IW(IW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(req_op), .addr(req_addr),
        .len(req_len), .sh_busy(sh_busy), .sh_done(sh_done), .sh_stat(sh_stat),
        .buf_data(rd_data), .buf_idx(rd_idx), .sh_start(sh_start), .sh_tx(sh_tx),
        .cs_n(cs_n), .busy(busy), .done(done), .error(error)
    );

    flash_seq_shift #(.DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(miso),
        .busy(sh_busy), .done(sh_done), .stat(sh_stat), .sck(sck), .mosi(mosi)
    );

    // R9: SCK is idle low outside a chip-select frame.
    assert_sck_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
endmodule

// File: tb/flash_wr_seq_test.sv
// Self-checking bench: a behavioural flash model logs every frame, and the log is judged
// against frames computed from each request.
module flash_wr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH    = 4;
    localparam int DIV      = 1;
    localparam int GAP_SCK  = 1;
    localparam int POLL_MAX = 4;
    localparam int LW       = $clog2(DEPTH + 1);
    localparam int IW       = $clog2(DEPTH);
    localparam int GAP_CLK  = GAP_SCK * 2 * DIV;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = 24'h0;
    logic [LW-1:0] req_len = '0;
    logic start = 1'b0, buf_we = 1'b0;
    logic [IW-1:0] buf_idx = '0;
    logic [7:0] buf_wdata = 8'h0;
    logic busy, done, error, cs_n, sck, mosi;
    logic miso = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic [7:0] bmem [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_wr_seq #(.DEPTH(DEPTH), .DIV(DIV), .GAP_SCK(GAP_SCK), .POLL_MAX(POLL_MAX),
                   .WEL_CHECK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .start(start), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .busy(busy), .done(done), .error(error), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso)
    );

    // ---------------- flash model ----------------
    logic [7:0] lb [16][12];
    int ll [16];
    int nf = 0;
    int m_busy = 0, wip_left = 0;
    bit m_wel_ok = 1'b1, wel = 1'b0;
    logic [7:0] cur = 8'h0, ssh = 8'h0;
    logic [7:0] fb [12];
    int bc = 0, nb = 0;

    always @(negedge cs_n) begin
        bc = 0; nb = 0; cur = 8'h0;
    end

    always @(posedge sck) if (cs_n === 1'b0) begin
        cur = {cur[6:0], mosi};
        bc++;
        if (bc == 8) begin
            if (nb < 12) fb[nb] = cur;
            nb++;
            bc = 0;
            if (nb == 1 && cur == 8'h05) ssh = {6'b0, wel, (wip_left > 0)};
        end
    end

    always @(negedge sck) if (cs_n === 1'b0 && nb >= 1 && fb[0] == 8'h05) begin
        miso = ssh[7];
        ssh = {ssh[6:0], 1'b0};
    end

    always @(posedge cs_n) if (nb > 0) begin
        if (nf < 16) begin
            ll[nf] = nb;
            for (int k = 0; k < 12; k++) lb[nf][k] = (k < nb) ? fb[k] : 8'h00;
        end
        nf++;
        case (fb[0])
            8'h06: wel = m_wel_ok;
            8'h20, 8'h02, 8'h71: begin wip_left = m_busy; wel = 1'b0; end
            8'h05: if (wip_left > 0) wip_left--;
            default: ;
        endcase
        nb = 0;
    end

    // ---------------- monitors ----------------
    int hi = 0, gap_bad = 0, mode_bad = 0;
    logic pm = 1'b0;
    always @(posedge clk) begin
        if (cs_n === 1'b1) hi++;
        else begin
            if (hi > 0 && hi < GAP_CLK) gap_bad++;
            hi = 0;
        end
    end
    always @(negedge clk) if (rst_n) begin
        if (sck === 1'b1 && mosi !== pm) mode_bad++;
        if (cs_n === 1'b1 && sck === 1'b1) mode_bad++;
        pm = mosi;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_buf(input int seed);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            bmem[k] = 8'((seed * 29 + k * 53 + 7) & 8'hFF);
            buf_we = 1'b1; buf_idx = IW'(k); buf_wdata = bmem[k];
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    function automatic logic [7:0] exp_cmd(input int op, input logic [23:0] a, input int k);
        logic [23:0] ea;
        ea = (op == 0) ? 24'h000002 : a;
        case (k)
            0: return (op == 0) ? 8'h71 : (op == 1) ? 8'h20 : 8'h02;
            1: return ea[23:16];
            2: return ea[15:8];
            3: return ea[7:0];
            default: return bmem[k - 4];
        endcase
    endfunction

    task automatic run_op(input int op, input logic [23:0] a, input int len, input int bsy, input bit welok);
        int t;
        bit valid, experr;
        int npoll, clen;
        string rq;
        m_busy = bsy; m_wel_ok = welok; wip_left = 0; wel = 1'b0;
        nf = 0; gap_bad = 0; mode_bad = 0;
        @(negedge clk);
        req_op = 2'(op); req_addr = a; req_len = LW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R6", "done within bound", t, 0);
        experr = 1'b0;
        valid = (op != 3) && (op != 2 || (len >= 1 && len <= DEPTH));
        if (!valid) begin
            chk(t == 0, "R10", "reject latency", t, 0);
            chk(error === 1'b1, "R10", "reject error", int'(error), 1);
            repeat (4) @(negedge clk);
            chk(nf == 0, "R10", "no frame on reject", nf, 0);
            return;
        end
        chk(nf >= 1 && ll[0] == 1 && lb[0][0] == 8'h06, "R1", "wren frame", int'(lb[0][0]), 8'h06);
        chk(nf >= 2 && ll[1] == 2 && lb[1][0] == 8'h05, "R2", "latch check frame", int'(lb[1][0]), 8'h05);
        if (!welok) begin
            chk(nf == 2, "R2", "frames after latch fail", nf, 2);
            chk(error === 1'b1, "R2", "latch fail error", int'(error), 1);
        end else begin
            clen = (op == 0) ? 5 : (op == 1) ? 4 : 4 + len;
            rq = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
            chk(nf >= 3 && ll[2] == clen, rq, "command length", ll[2], clen);
            for (int k = 0; k < clen; k++)
                chk(lb[2][k] == exp_cmd(op, a, k), rq, $sformatf("command byte %0d", k),
                    int'(lb[2][k]), int'(exp_cmd(op, a, k)));
            npoll = (bsy + 1 <= POLL_MAX) ? bsy + 1 : POLL_MAX;
            experr = (bsy >= POLL_MAX);
            rq = experr ? "R7" : "R6";
            chk(nf == 3 + npoll, rq, "frame count", nf, 3 + npoll);
            chk(error === experr, rq, "error flag", int'(error), int'(experr));
            for (int f = 3; f < nf && f < 16; f++)
                chk(ll[f] == 2 && lb[f][0] == 8'h05, "R6", "poll frame", int'(lb[f][0]), 8'h05);
        end
        chk(gap_bad == 0, "R8", "cs high gap", gap_bad, 0);
        chk(mode_bad == 0, "R9", "mode 0 timing", mode_bad, 0);
        chk(busy === 1'b0 && cs_n === 1'b1, "R6", "idle after done", int'(busy), 0);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(cs_n === 1'b1 && sck === 1'b0, "R11", "reset pins", int'({cs_n, sck}), 2);
        chk(busy === 1'b0 && done === 1'b0, "R11", "reset status", int'({busy, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: config write, address input ignored, several busy lengths
        load_buf(0);
        bmem[0] = 8'h02;
        @(negedge clk); buf_we = 1'b1; buf_idx = '0; buf_wdata = 8'h02;
        @(negedge clk); buf_we = 1'b0;
        for (int b = 0; b < 3; b++) run_op(0, 24'h123456 + 24'(b), 1, b, 1'b1);

        // R4: sector erase across the address range
        run_op(1, 24'h000000, 0, 0, 1'b1);
        run_op(1, 24'h001000, 0, 1, 1'b1);
        run_op(1, 24'h7FFFFF, 0, 2, 1'b1);
        run_op(1, 24'h5A5AA5, 0, 3, 1'b1);

        // R5: page program sweep over every legal length
        for (int n = 1; n <= DEPTH; n++) begin
            load_buf(n);
            run_op(2, 24'h010000 + 24'(n * 24'h111), n, n % 3, 1'b1);
        end

        // R2: latch not set aborts before the command
        run_op(1, 24'h002000, 0, 0, 1'b0);
        run_op(2, 24'h003000, 2, 0, 1'b0);

        // R7: poll budget exhausted, and R6 at the last allowed poll
        run_op(1, 24'h004000, 0, POLL_MAX, 1'b1);
        run_op(2, 24'h005000, 3, POLL_MAX + 5, 1'b1);
        run_op(1, 24'h006000, 0, POLL_MAX - 1, 1'b1);

        // R10: malformed requests
        run_op(3, 24'h0, 0, 0, 1'b1);
        run_op(2, 24'h0, 0, 0, 1'b1);
        run_op(2, 24'h0, DEPTH + 1, 0, 1'b1);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule